// File: doc/BRIEF.md
# Countdown-Completion Register Memory Slave

This block is a small word-addressed register memory that sits on the slave side of a synchronous point-to-point bus. The master issues one-cycle read or write strobes. The address and write data are present only during that single cycle, so the slave latches them itself. Each access then takes a fixed number of cycles, set by a parameter from 1 to 6.

The slave does not report completion with a single acknowledge pulse. It drives a two-bit count of the cycles left before the transaction finishes. The count saturates at 3, falls by one each cycle, and reaches 0 when the read word is on the data output or the write has been stored. This lets a pipelined master plan ahead.

Read data is registered and stays on the output until a later read completes. The memory word may be narrower than the 32-bit data path. Read results are zero-extended, and write data above the word width is dropped. Two constant outputs advertise how far the master may overlap commands. A new command is taken in the very cycle in which the previous result appears, which is level-1 overlap.

Top module: `rcnt_mem_slave`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `busy_cnt` is 0 and `rdata` is 0. Reset also clears every memory word to 0.
- R2: The address and write data are sampled only in the cycle in which `rd` or `wr` is high. Changing `addr` or `wdata` in any later cycle has no effect on that transaction.
- R3: The cycle after a command is accepted, `busy_cnt` shows min(LATENCY, 3). From then on it shows min(remaining, 3), where `remaining` falls by one each cycle. It reaches 0 exactly LATENCY+1 cycles after the strobe cycle.
- R4: A read completes in the cycle where `busy_cnt` returns to 0. In that cycle `rdata` holds the addressed word, zero-extended to 32 bits.
- R5: `rdata` changes only when a read completes. It holds its value while a transaction is pending, through write completions and while idle.
- R6: A write stores `wdata[DW-1:0]` at the latched address when it completes, and bits above DW are ignored. A read issued afterwards returns the new word.
- R7: An idle slave with no strobe keeps `busy_cnt` at 0.
- R8: A `rd` or `wr` strobe that arrives while `busy_cnt` is non-zero is ignored. The countdown of the pending transaction continues unchanged, and neither memory nor `rdata` is affected.
- R9: A command strobed in the cycle where `busy_cnt` is 0 is accepted. This includes the completion cycle of the previous transaction, so back-to-back transactions take LATENCY+1 cycles each.
- R10: If `rd` and `wr` are high in the same accepted cycle, the command is a write, and `rdata` is not updated on completion.
- R11: `rd_level` and `wr_level` are constant and equal to the RD_LEVEL and WR_LEVEL parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, valid with a strobe |
| wdata | input | 32 | Write data, valid with `wr` |
| rd | input | 1 | One-cycle read strobe |
| wr | input | 1 | One-cycle write strobe |
| rdata | output | 32 | Held read result, zero-extended |
| busy_cnt | output | 2 | Saturating count of cycles until completion, 0 = done/idle |
| rd_level | output | 2 | Static read overlap level |
| wr_level | output | 2 | Static write overlap level |

## Verification
A corrupted remaining-cycle counter shows up on `busy_cnt` in the very next cycle: a count that jumps, stalls below 3, or never reaches 0. The bench compares `busy_cnt` against the expected countdown at every cycle of every transaction. A wrong latched address, or lost write data, surfaces on `rdata` at the next read of that word. An accepted stray strobe during a busy period restarts the countdown at 3 within one cycle, which the bench catches immediately.

// File: rtl/rcnt_mem_slave.sv
module rcnt_mem_slave #(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int LATENCY  = 3,
  parameter int RD_LEVEL = 1,
  parameter int WR_LEVEL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          rd,
  input  logic          wr,
  output logic [31:0]   rdata,
  output logic [1:0]    busy_cnt,
  output logic [1:0]    rd_level,
  output logic [1:0]    wr_level
);
  localparam int         DEPTH = 1 << AW;
  localparam logic [2:0] LAT   = 3'(LATENCY);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          is_wr_q;
  logic [2:0]    rem;
  logic [DW-1:0] rword;

  wire accept = (rem == 3'd0) && (rd || wr);
  wire finish = (rem == 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      rword   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (finish) begin
        if (is_wr_q) mem[addr_q] <= wdata_q;
        else         rword       <= mem[addr_q];
      end
      if (accept) begin
        rem     <= LAT;
        addr_q  <= addr;
        wdata_q <= wdata[DW-1:0];
        is_wr_q <= wr;
      end else if (rem != 3'd0) begin
        rem <= rem - 3'd1;
      end
    end
  end

  assign rdata    = 32'(rword);
  assign busy_cnt = (rem > 3'd3) ? 2'd3 : rem[1:0];
  assign rd_level = 2'(RD_LEVEL);
  assign wr_level = 2'(WR_LEVEL);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (busy_cnt == 2'd0 && rdata == 32'd0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt == 2'd1 || busy_cnt == 2'd2) |=> busy_cnt == $past(busy_cnt) - 2'd1);

  assert_count_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt == 2'd3) |=> busy_cnt >= 2'd2);

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != 2'd1) |=> $stable(rdata));

  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt == 2'd0 && !rd && !wr) |=> busy_cnt == 2'd0);

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != 2'd0 && busy_cnt != 2'd3) |=> busy_cnt != 2'd3);
endmodule

// File: tb/rcnt_mem_slave_tb.sv
module rcnt_mem_slave_tb_top;
  localparam int AW = 4, DW = 16, LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [31:0]   rdata;
  logic [1:0]    busy_cnt, rd_level, wr_level;

  rcnt_mem_slave #(.AW(AW), .DW(DW), .LATENCY(LAT), .RD_LEVEL(1), .WR_LEVEL(0)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .rdata(rdata), .busy_cnt(busy_cnt), .rd_level(rd_level), .wr_level(wr_level));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [1 << AW];
  logic [31:0]   exp_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] exp_cnt(int n);
    int r = LAT - n + 1;
    return (r > 3) ? 2'd3 : 2'(r);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge with busy_cnt == 0
  task automatic txn(bit w, bit r, logic [AW-1:0] a, logic [31:0] d, bit inject);
    addr = a; wdata = d; rd = r; wr = w;
    for (int n = 1; n <= LAT + 1; n++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
      addr = AW'($urandom); wdata = $urandom;
      chk(32'(busy_cnt), 32'(exp_cnt(n)), (n == 1) ? "R3 start" : "R3/R8 countdown");
      if (n <= LAT) chk(rdata, exp_rd, "R5 hold while busy");
      if (inject && n == 1 && LAT >= 2) begin
        if ($urandom % 2) rd = 1'b1; else wr = 1'b1;
      end
    end
    if (w) begin
      model[a] = d[DW-1:0];
      chk(rdata, exp_rd, "R10/R5 write leaves rdata");
    end else begin
      exp_rd = 32'(model[a]);
      chk(rdata, exp_rd, "R4/R2/R6 read result");
    end
  endtask

  initial begin
    wait (cyc == 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(32'(busy_cnt), 0, "R1 count in reset");
    chk(rdata, 0, "R1 rdata in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(32'(busy_cnt), 0, "R1 count after reset");
    chk(rdata, 0, "R1 rdata after reset");
    chk(32'(rd_level), 1, "R11 rd level");
    chk(32'(wr_level), 0, "R11 wr level");

    txn(1'b0, 1'b1, 4'd5, 32'h0, 1'b0);                 // R1 memory cleared
    txn(1'b1, 1'b0, 4'd5, 32'hDEAD_BEEF, 1'b0);         // R6 upper bits dropped
    txn(1'b0, 1'b1, 4'd5, 32'h0, 1'b0);
    chk(rdata, 32'h0000_BEEF, "R6 zero-extend");
    txn(1'b1, 1'b0, 4'd0, 32'h1234_0F0F, 1'b1);         // R8 stray strobe
    txn(1'b0, 1'b1, 4'd0, 32'h0, 1'b1);
    chk(rdata, 32'h0000_0F0F, "R8 stray ignored");
    txn(1'b1, 1'b1, 4'd15, 32'h0000_A5A5, 1'b0);        // R10 both strobes
    txn(1'b0, 1'b1, 4'd15, 32'h0, 1'b0);
    chk(rdata, 32'h0000_A5A5, "R10 write wins");

    repeat (5) begin
      @(negedge clk);
      chk(32'(busy_cnt), 0, "R7 idle count");
      chk(rdata, exp_rd, "R5 idle hold");
    end

    for (int k = 0; k < 400; k++) begin                 // R9 back-to-back
      bit w = ($urandom % 2) == 1;
      txn(w, !w, AW'($urandom), $urandom, ($urandom % 4) == 0);
      if (($urandom % 8) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule